// File: doc/BRIEF.md
# Cascaded Interrupt Cause Controller

This block gathers 96 interrupt sources into one CPU interrupt line and a vector that names the source to service. Sixty-four of them come from on-chip units as level signals and land in two main cause words, low and high. Thirty-two general-purpose pins are captured on their rising edges into a pin cause word. The pin cause word is folded back into four summary bits of the high main word. Software reads the cause words and writes three enable words. It acknowledges a pin event by writing zeros over the pin cause bits it has handled.

The vector is found in stages. Eligible low bits are searched first, and the lowest set index wins. When none is found, the high word is searched. If the winner there is one of the pin summary bits, the search moves on into the pin cause word. Some cause positions are reserved and never take part. When nothing is eligible, the controller reports a spurious code instead of a vector and holds the interrupt line low.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, all three enable words and the pin cause word read 0, `irq` is low and `vec` shows the spurious code 8'hFE.
- R2: Low cause bit i gives vector i. High cause bit i (i below 24) gives vector 32+i. Pin cause bit n gives vector 64+n.
- R3: The lowest eligible vector is reported. Any eligible low bit beats every high bit and every pin bit, and any eligible high bit below 24 beats every pin bit.
- R4: Only low bits in the pattern 32'h3DFFFFFE and high bits in the pattern 32'h0F000DB7 can be eligible. Other cause bits never produce a vector.
- R5: A source is eligible only while its bit in the matching enable word is 1. Enable words are written whole.
- R6: High cause bits 24 to 27 show the OR of the enabled pin cause bits in groups of eight: bits 0-7 drive bit 24, 8-15 drive bit 25, 16-23 drive bit 26 and 24-31 drive bit 27. The `hi_src` inputs at those positions are ignored.
- R7: A pin cause bit is set by a rising edge on its pin, and only by an edge. A pin held high does not set the bit again after it has been cleared.
- R8: A write to the pin cause word clears each bit written as 0 and keeps each bit written as 1. A rising edge in the same cycle as a clearing write leaves the bit set.
- R9: `irq` is high exactly when a vector below 96 is reported. Otherwise `vec` is 8'hFE.
- R10: Register map, word address on `addr`: 0 low cause (read only), 1 high cause (read only), 2 pin cause, 3 low enable, 4 high enable, 5 pin enable. `rdata` shows the addressed word combinationally. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_src | input | 32 | Level sources for the low main cause word |
| hi_src | input | 32 | Level sources for the high main cause word (bits 24-27 unused) |
| gpp_pin | input | 32 | General-purpose pins, captured on rising edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | CPU interrupt request |
| vec | output | 8 | Lowest pending vector, or 8'hFE when spurious |

## Verification
The bench sweeps every single low bit and every single high bit, so a wrong reserved-bit pattern shows up as a vector for a reserved position or as a lost vector. It walks all 32 pins through edge, report, summary readback and acknowledge, which catches a wrong group mapping or an off-by-64 vector. It then targets the cycle where an edge meets a clearing write, a pin held high after its acknowledge, and a partial acknowledge. A design that lets the clear win, captures levels instead of edges, or clears bits written as 1 would report a lost, repeated or missing pin vector. Priority patterns that mix low, high and pin sources expose a search that takes the highest bit or that looks at the high word before the low word.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int          W       = 32,
  parameter int          GRP     = 8,
  parameter int          SUM_LSB = 24,
  parameter int          AW      = 3,
  parameter int          VW      = 8,
  parameter logic [31:0] LO_KEEP = 32'h3DFF_FFFE,
  parameter logic [31:0] HI_KEEP = 32'h0F00_0DB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  lo_src,
  input  logic [W-1:0]  hi_src,
  input  logic [W-1:0]  gpp_pin,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq,
  output logic [VW-1:0] vec
);
  localparam int          NSUM  = W / GRP;
  localparam int          IW    = $clog2(W);
  localparam logic [VW-1:0] SPUR = {{(VW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] A_LOC = AW'(0), A_HIC = AW'(1), A_GPC = AW'(2),
                            A_LOM = AW'(3), A_HIM = AW'(4), A_GPM = AW'(5);

  logic [W-1:0] lo_mask, hi_mask, gpp_mask, gpp_cause, gpp_prev;
  logic [W-1:0] lo_cause, hi_cause, lo_hit, hi_hit, gpp_hit, rise;
  logic [NSUM-1:0] summ;
  logic [IW-1:0] lo_idx, hi_idx, gp_idx;
  logic spur;

  wire unused_hi_sum = ^hi_src[SUM_LSB +: NSUM];

  function automatic logic [IW-1:0] lowest(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--)
      if (v[i]) r = IW'(i);
    return r;
  endfunction

  assign rise     = gpp_pin & ~gpp_prev;
  assign gpp_hit  = gpp_cause & gpp_mask;

  for (genvar g = 0; g < NSUM; g++) begin : g_sum
    assign summ[g] = |gpp_hit[g*GRP +: GRP];
  end

  assign lo_cause = lo_src;
  always_comb begin
    hi_cause = hi_src;
    hi_cause[SUM_LSB +: NSUM] = summ;
  end

  assign lo_hit = lo_cause & LO_KEEP[W-1:0] & lo_mask;
  assign hi_hit = hi_cause & HI_KEEP[W-1:0] & hi_mask;
  assign lo_idx = lowest(lo_hit);
  assign hi_idx = lowest(hi_hit);
  assign gp_idx = lowest(gpp_hit);

  always_comb begin
    spur = 1'b0;
    vec  = SPUR;
    if (|lo_hit)
      vec = VW'(lo_idx);
    else if (|hi_hit) begin
      if (int'(hi_idx) >= SUM_LSB) begin
        if (|gpp_hit) vec = VW'(2 * W) + VW'(gp_idx);
        else          spur = 1'b1;
      end else
        vec = VW'(W) + VW'(hi_idx);
    end else
      spur = 1'b1;
  end

  assign irq = ~spur;

  always_comb begin
    case (addr)
      A_LOC:   rdata = lo_cause;
      A_HIC:   rdata = hi_cause;
      A_GPC:   rdata = gpp_cause;
      A_LOM:   rdata = lo_mask;
      A_HIM:   rdata = hi_mask;
      A_GPM:   rdata = gpp_mask;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpp_prev  <= '0;
      gpp_cause <= '0;
      lo_mask   <= '0;
      hi_mask   <= '0;
      gpp_mask  <= '0;
    end else begin
      gpp_prev <= gpp_pin;
      if (wr_en && addr == A_GPC) gpp_cause <= (gpp_cause & wdata) | rise;
      else                        gpp_cause <= gpp_cause | rise;
      if (wr_en && addr == A_LOM) lo_mask  <= wdata;
      if (wr_en && addr == A_HIM) hi_mask  <= wdata;
      if (wr_en && addr == A_GPM) gpp_mask <= wdata;
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk #(
  parameter int          W       = 32,
  parameter int          AW      = 3,
  parameter int          VW      = 8,
  parameter logic [31:0] LO_KEEP = 32'h3DFF_FFFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  lo_src,
  input logic [W-1:0]  gpp_pin,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  gpp_cause,
  input logic [W-1:0]  lo_mask,
  input logic          irq,
  input logic [VW-1:0] vec
);
  localparam logic [AW-1:0] A_GPC = AW'(2);
  localparam logic [VW-1:0] SPUR  = {{(VW-1){1'b1}}, 1'b0};

  p_irq_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec != SPUR));

  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int'(vec) < 3 * W));

  p_low_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lo_src & lo_mask & LO_KEEP[W-1:0])) |-> (int'(vec) < W));

  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpp_pin[0]) |=> gpp_cause[0]);

  p_zero_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GPC && !wdata[0] && !gpp_pin[0]) |=> !gpp_cause[0]);

  p_one_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GPC && wdata[0] && gpp_cause[0]) |=> gpp_cause[0]);
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(.W(W), .AW(AW), .VW(VW), .LO_KEEP(LO_KEEP)) u_chk (.*);

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  localparam logic [31:0] LOK = 32'h3DFF_FFFE;
  localparam logic [31:0] HIK = 32'h0F00_0DB7;
  localparam int SP = 254;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] lo_src = '0, hi_src = '0, gpp_pin = '0, wdata = '0;
  logic [2:0] addr = '0;
  logic [31:0] rdata;
  logic irq;
  logic [7:0] vec;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (.*);

  function automatic int low1(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input int exp);
    #1;
    chk(req, int'(vec), exp);
    chk({req, " irq"}, int'(irq), (exp == SP) ? 0 : 1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [31:0] p);
    @(negedge clk); gpp_pin = p;
    @(negedge clk); gpp_pin = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 2; a < 6; a++) begin rd(3'(a), d); chk("R1 reg zero", int'(d), 0); end
    chk_vec("R1 spurious after reset", SP);
    lo_src = 32'hFFFF_FFFF;
    chk_vec("R5 all masked", SP);
    lo_src = '0;

    // R10 register map
    wr(3, 32'hA5A5_0001); wr(4, 32'h0F0F_0002); wr(5, 32'h1234_5678);
    rd(3, d); chk("R10 low enable", int'(d), int'(32'hA5A5_0001));
    rd(4, d); chk("R10 high enable", int'(d), int'(32'h0F0F_0002));
    rd(5, d); chk("R10 pin enable", int'(d), int'(32'h1234_5678));
    rd(6, d); chk("R10 unused addr", int'(d), 0);
    lo_src = 32'h0000_00C3; hi_src = 32'h0000_0500;
    rd(0, d); chk("R10 low cause", int'(d), int'(32'h0000_00C3));
    rd(1, d); chk("R10 high cause", int'(d), int'(32'h0000_0500));
    lo_src = '0; hi_src = '0;

    wr(3, '1); wr(4, '1); wr(5, '1);

    // R2 R4 low sweep
    for (int i = 0; i < 32; i++) begin
      lo_src = 32'(1) << i;
      chk_vec("R2 R4 low bit", LOK[i] ? i : SP);
    end
    lo_src = '0;
    // R2 R4 R6 high sweep
    for (int i = 0; i < 32; i++) begin
      hi_src = 32'(1) << i;
      chk_vec("R2 R4 R6 high bit", (HIK[i] && i < 24) ? 32 + i : SP);
    end
    hi_src = 32'h0F00_0000;
    rd(1, d); chk("R6 hi_src summary ignored", int'(d), 0);
    hi_src = '0;

    // R3 priority patterns
    for (int i = 1; i <= 24; i++) begin
      p = (32'(i) * 32'h9E37_79B1) ^ 32'h0000_1234;
      lo_src = p; hi_src = 32'h0000_0DB0;
      chk_vec("R3 low before high", (low1(p & LOK) >= 0) ? low1(p & LOK) : 36);
    end
    lo_src = 32'h0000_0001; hi_src = 32'h0000_0C00;
    chk_vec("R3 reserved low leaves high", 42);
    lo_src = '0; hi_src = '0;

    // R2 R6 R7 R8 pin walk
    for (int n = 0; n < 32; n++) begin
      pulse(32'(1) << n);
      chk_vec("R2 R7 pin vector", 64 + n);
      rd(1, d); chk("R6 summary group", int'(d[27:24]), 1 << (n / 8));
      wr(2, ~(32'(1) << n));
      chk_vec("R8 acknowledge", SP);
    end

    // R3 low and high beat pin
    pulse(32'h0000_0080);
    lo_src = 32'h0000_0020;
    chk_vec("R3 low beats pin", 5);
    lo_src = '0; hi_src = 32'h0000_0004;
    chk_vec("R3 high beats pin", 34);
    hi_src = '0;
    // R5 R6 pin enable
    wr(5, ~32'h0000_0080);
    chk_vec("R5 pin disabled", SP);
    rd(1, d); chk("R6 summary masked", int'(d[27:24]), 0);
    rd(2, d); chk("R5 cause kept", int'(d), int'(32'h0000_0080));
    wr(5, '1);
    chk_vec("R5 pin re-enabled", 71);
    wr(2, 32'h0);
    // R5 low enable
    lo_src = 32'h0000_0008; hi_src = 32'h0000_0002;
    wr(3, ~32'h0000_0008);
    chk_vec("R5 low disabled falls to high", 33);
    wr(3, '1);
    chk_vec("R5 low re-enabled", 3);
    lo_src = '0; hi_src = '0;

    // R7 held high
    @(negedge clk); gpp_pin = 32'h0000_0200;
    @(negedge clk);
    wr(2, ~32'h0000_0200);
    repeat (3) @(negedge clk);
    rd(2, d); chk("R7 held pin no reset", int'(d), 0);
    chk_vec("R7 held pin no vector", SP);
    gpp_pin = '0;

    // R8 same cycle set and clear
    @(negedge clk);
    gpp_pin = 32'h0000_1000; wr_en = 1'b1; addr = 3'd2; wdata = ~32'h0000_1000;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; gpp_pin = '0;
    rd(2, d); chk("R8 set wins", int'(d), int'(32'h0000_1000));
    pulse(32'h0010_0000);
    chk_vec("R8 two pending", 76);
    wr(2, ~32'h0000_1000);
    rd(2, d); chk("R8 ones kept", int'(d), int'(32'h0010_0000));
    chk_vec("R8 next pin", 84);
    wr(2, 32'h0);
    chk_vec("R9 all clear", SP);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule